// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block sits beside a processor core and decides which of sixteen event levels the core should service next. Level 0 has the highest priority and level 15 the lowest. Incoming event requests are captured in a pending-latch register. A mask register gates them, and a global enable gates the nine general-purpose levels (7 to 15) as a group. Of the levels that remain eligible, the one with the lowest index is presented to the core as a level number together with a request flag.

The core answers with an acknowledge when it takes the presented event. It signals return-from-event when a handler finishes. The block keeps an in-service register so that a handler can only be pre-empted by a strictly higher level. Levels 0 to 6 are fixed classes: emulation, reset, non-maskable interrupt, exception, a reserved slot, hardware error and core timer. Levels 14 and 15 are intended for software-raised events.

A small register port gives supervisor-mode access to the pending-latch register and the mask register. Software can write the pending-latch register to cancel pending events, and can write the mask register to unmask or mask levels.

Top module: `cec_core`

## Requirements
- R1: After reset, no request is issued, the pending-latch register reads 0, the global enable is off, nothing is in service, and the mask register reads 0x0000002F.
- R2: A one on `evt_raise[i]` at a clock edge sets pending bit i. Register reads are 32 bits wide and bits 31..16 always read as zero.
- R3: A mask bit of 1 unmasks its level. A latched event whose mask bit is 0 issues no request but stays visible in the pending-latch register.
- R4: Mask bits 0, 1, 2, 3 and 5 always read as 1 and ignore writes. Level 4 never latches, never requests, and its mask bit always reads 0.
- R5: `gie_set` turns the global enable on and `gie_clr` turns it off; when both are high in one cycle, `gie_clr` wins. While the enable is off, levels 7 to 15 issue no request, and levels 0 to 6 are not affected.
- R6: Among latched, unmasked and enabled levels, `irq_level` shows the lowest index.
- R7: An `ack` while `irq_req` is high clears the pending bit of `irq_level` and marks that level as in service. An `ack` while `irq_req` is low has no effect.
- R8: A request is issued only when the winning level has a lower index than every level in service.
- R9: `rfe` clears the in-service bit with the lowest index. When `ack` and `rfe` fall in the same cycle, both take effect.
- R10: A write to address 0 (the pending-latch register) in supervisor mode clears each bit where the write data is 1 and the mask bit is 0. All other bits are unchanged. A raise of the same bit in the same cycle wins over the clear.
- R11: With `supervisor` low, register writes are ignored and register reads return zero. Address 1 selects the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_raise | input | 16 | Event capture strobes, one per level |
| supervisor | input | 1 | Core is in supervisor mode |
| gie_set | input | 1 | Turn the general-purpose enable on |
| gie_clr | input | 1 | Turn the general-purpose enable off |
| ack | input | 1 | Core accepts the presented event |
| rfe | input | 1 | Core returns from the current handler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = pending-latch register, 1 = mask register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | An eligible event is waiting for the core |
| irq_level | output | 4 | Level number of that event |

## Verification
The sensitive overlaps are an acknowledge that coincides with a return-from-event, and a software cancel that coincides with a new raise of the same level. Both are first provoked by directed steps. In the first, a nested handler is entered in the very cycle the outer one returns, and the level that is still in service must block a lower pending event afterwards. In the second, the bit must stay latched. The random phase then overlaps raises, acknowledges, returns, enable changes and register writes freely. Every cycle's request and level are judged against a bench model built from the requirements.

// File: rtl/cec_pkg.sv
package cec_pkg;

    typedef enum logic {
        ADDR_LATCH = 1'b0,
        ADDR_MASK  = 1'b1
    } cec_addr_e;

endpackage

// File: rtl/cec_prio_enc.sv
module cec_prio_enc #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [LW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/cec_rd_mux.sv
module cec_rd_mux
    import cec_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic          supervisor,
    input  cec_addr_e     addr,
    input  logic [N-1:0]  latch,
    input  logic [N-1:0]  mask,
    output logic [DW-1:0] rdata
);
    localparam int PADW = DW - N;

    always_comb begin
        if (!supervisor)
            rdata = '0;
        else if (addr == ADDR_MASK)
            rdata = {{PADW{1'b0}}, mask};
        else
            rdata = {{PADW{1'b0}}, latch};
    end
endmodule

// File: rtl/cec_core.sv
module cec_core
    import cec_pkg::*;
#(
    parameter int              N_LVL    = 16,
    parameter int              DW       = 32,
    parameter int              GP_FIRST = 7,
    parameter logic [N_LVL-1:0] NOMASK  = 16'h002F,
    parameter logic [N_LVL-1:0] RSVD    = 16'h0010,
    parameter int              LW       = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] evt_raise,
    input  logic             supervisor,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             ack,
    input  logic             rfe,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_req,
    output logic [LW-1:0]    irq_level
);
    localparam logic [N_LVL-1:0] FIXED   = NOMASK | RSVD;
    localparam logic [N_LVL-1:0] SYS_LVL = N_LVL'((1 << GP_FIRST) - 1);

    typedef struct packed {
        logic [N_LVL-1:0] latch;
        logic [N_LVL-1:0] mask;
        logic [N_LVL-1:0] ipend;
        logic             gie;
    } cec_state_t;

    cec_state_t st_d, st_q;

    logic [N_LVL-1:0] latch_q, mask_q, ipend_q;
    logic             gie_q;
    assign latch_q = st_q.latch;
    assign mask_q  = st_q.mask;
    assign ipend_q = st_q.ipend;
    assign gie_q   = st_q.gie;

    cec_addr_e addr_e;
    assign addr_e = cec_addr_e'(reg_addr);

    // eligibility and priority
    logic [N_LVL-1:0] gate, eligible;
    logic             win_vld, svc_vld;
    logic [LW-1:0]    win_idx, svc_idx;

    assign gate     = gie_q ? {N_LVL{1'b1}} : SYS_LVL;
    assign eligible = latch_q & mask_q & gate;

    cec_prio_enc #(.N(N_LVL), .LW(LW)) u_win (
        .vec(eligible), .valid(win_vld), .idx(win_idx)
    );
    cec_prio_enc #(.N(N_LVL), .LW(LW)) u_svc (
        .vec(ipend_q), .valid(svc_vld), .idx(svc_idx)
    );

    assign irq_req   = win_vld && (!svc_vld || (win_idx < svc_idx));
    assign irq_level = win_idx;

    cec_rd_mux #(.N(N_LVL), .DW(DW)) u_rd (
        .supervisor(supervisor), .addr(addr_e),
        .latch(latch_q), .mask(mask_q), .rdata(reg_rdata)
    );

    // next state
    logic             accept, sw_wr;
    logic [N_LVL-1:0] acc_bit, ret_bit, sw_clr;

    always_comb begin
        accept  = ack && irq_req;
        sw_wr   = reg_wr && supervisor;
        acc_bit = accept ? (N_LVL'(1) << win_idx) : '0;
        ret_bit = (rfe && svc_vld) ? (N_LVL'(1) << svc_idx) : '0;
        sw_clr  = (sw_wr && addr_e == ADDR_LATCH) ? (reg_wdata[N_LVL-1:0] & ~mask_q) : '0;

        st_d       = st_q;
        st_d.latch = ((st_q.latch & ~acc_bit & ~sw_clr) | evt_raise) & ~RSVD;
        if (sw_wr && addr_e == ADDR_MASK)
            st_d.mask = (reg_wdata[N_LVL-1:0] & ~FIXED) | NOMASK;
        st_d.ipend = (st_q.ipend & ~ret_bit) | acc_bit;
        if (gie_clr)
            st_d.gie = 1'b0;
        else if (gie_set)
            st_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '0;
            st_q.mask  <= NOMASK;
            st_q.ipend <= '0;
            st_q.gie   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cec_core_chk.sv
module cec_core_chk #(
    parameter int              N_LVL    = 16,
    parameter int              DW       = 32,
    parameter int              GP_FIRST = 7,
    parameter logic [N_LVL-1:0] RSVD    = 16'h0010,
    parameter int              LW       = $clog2(N_LVL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_LVL-1:0] evt_raise,
    input logic             ack,
    input logic             rfe,
    input logic             irq_req,
    input logic [LW-1:0]    irq_level,
    input logic [N_LVL-1:0] latch_q,
    input logic [N_LVL-1:0] ipend_q,
    input logic             gie_q,
    input logic [DW-1:0]    reg_rdata
);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:N_LVL] == '0);

    // R2
    req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> latch_q[irq_level]);

    // R4
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q & RSVD) == '0);

    // R5
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie_q && irq_req) |-> (int'(irq_level) < GP_FIRST));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && !evt_raise[irq_level]) |=> !latch_q[$past(irq_level)]);

    // R7
    ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> ipend_q[$past(irq_level)]);

    // R8
    nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((ipend_q & ({N_LVL{1'b1}} >> (N_LVL - 1 - int'(irq_level)))) == '0));

    // R9
    rfe_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !(ack && irq_req) && ipend_q != '0)
            |=> $countones(ipend_q) == $past($countones(ipend_q)) - 1);
endmodule

bind cec_core cec_core_chk #(
    .N_LVL(N_LVL), .DW(DW), .GP_FIRST(GP_FIRST), .RSVD(RSVD), .LW(LW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_raise(evt_raise), .ack(ack), .rfe(rfe),
    .irq_req(irq_req), .irq_level(irq_level), .latch_q(latch_q),
    .ipend_q(ipend_q), .gie_q(gie_q), .reg_rdata(reg_rdata)
);

// File: tb/cec_core_tb_top.sv
`timescale 1ns/1ps
module cec_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_raise = '0;
    logic        supervisor = 1'b1;
    logic        gie_set = 1'b0, gie_clr = 1'b0, ack = 1'b0, rfe = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [3:0]  irq_level;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_latch, m_mask, m_ipend;
    logic        m_gie;

    always #10 clk = ~clk;

    cec_core dut_i (
        .clk(clk), .rst_n(rst_n), .evt_raise(evt_raise), .supervisor(supervisor),
        .gie_set(gie_set), .gie_clr(gie_clr), .ack(ack), .rfe(rfe),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level)
    );

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 16;
    endfunction

    function automatic logic [4:0] expect_out();
        logic [15:0] el;
        int w, s;
        el = m_latch & m_mask & (m_gie ? 16'hFFFF : 16'h007F);
        w  = lowest(el);
        s  = lowest(m_ipend);
        if (w < 16 && w < s) return {1'b1, 4'(w)};
        return 5'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_latch = '0; m_mask = 16'h002F; m_ipend = '0; m_gie = 1'b0;
    endtask

    // one clock; inputs already driven after a falling edge
    task automatic step(input string tag);
        logic [4:0]  e;
        logic [15:0] ln, mn, pn, clrb;
        logic        gn;
        int          sv;
        #1;
        e = expect_out();
        check(tag, {27'd0, irq_req, (irq_req ? irq_level : 4'd0)},
                   {27'd0, e[4], (e[4] ? e[3:0] : 4'd0)});
        ln = m_latch; mn = m_mask; pn = m_ipend; gn = m_gie;
        if (ack && e[4]) ln[e[3:0]] = 1'b0;
        if (reg_wr && supervisor && !reg_addr) begin
            clrb = reg_wdata[15:0] & ~m_mask;
            ln   = ln & ~clrb;
        end
        ln = (ln | evt_raise) & ~16'h0010;
        if (reg_wr && supervisor && reg_addr) mn = (reg_wdata[15:0] & ~16'h003F) | 16'h002F;
        sv = lowest(m_ipend);
        if (rfe && sv < 16) pn[sv] = 1'b0;
        if (ack && e[4]) pn[e[3:0]] = 1'b1;
        if (gie_clr) gn = 1'b0; else if (gie_set) gn = 1'b1;
        @(posedge clk);
        m_latch = ln; m_mask = mn; m_ipend = pn; m_gie = gn;
        @(negedge clk);
        evt_raise = '0; gie_set = 0; gie_clr = 0; ack = 0; rfe = 0;
        reg_wr = 0; reg_wdata = '0; supervisor = 1'b1;
    endtask

    task automatic rd(input logic a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic a, input logic [31:0] d, input logic sup);
        reg_wr = 1; reg_addr = a; reg_wdata = d; supervisor = sup;
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 32'h0, "R1 latch after reset");
        rd(1, 32'h2F, "R1 mask after reset");
        step("R1 no request after reset");

        // R2 / R3 latched but masked
        evt_raise = 16'h0200; step("R3 masked level 9 silent");
        rd(0, 32'h0000_0200, "R2 R3 level 9 stays latched");
        // R5 unmasked but global enable off
        wr(1, 32'hFFFF_0200, 1); step("R5 mask write");
        rd(1, 32'h0000_022F, "R2 R4 mask readback upper zero");
        step("R5 gp blocked while disabled");
        gie_set = 1; step("R5 enable");
        step("R5 level 9 requested");
        // R4 reserved level and fixed mask bits
        evt_raise = 16'h0010; wr(1, 32'h0000_0000, 1); step("R4 raise reserved");
        rd(0, 32'h0000_0200, "R4 level 4 never latches");
        rd(1, 32'h0000_002F, "R4 fixed mask bits hold");
        wr(1, 32'hFFFF_FFFF, 1); step("R4 unmask all");
        rd(1, 32'h0000_FFEF, "R4 level 4 mask reads zero");
        // R6 priority, R7 accept, R8 nesting, R9 return
        evt_raise = 16'h0008; step("R6 raise 3");
        step("R6 level 3 wins over 9");
        ack = 1; step("R7 accept 3");
        rd(0, 32'h0000_0200, "R7 pending bit 3 cleared");
        step("R8 level 9 blocked under 3");
        evt_raise = 16'h0002; step("R8 raise 1");
        ack = 1; rfe = 1; step("R9 accept 1 while returning from 3");
        step("R9 level 9 blocked under 1");
        rfe = 1; step("R9 return from 1");
        step("R9 level 9 requested again");
        // R7 ack without request ignored
        gie_clr = 1; step("R5 disable");
        ack = 1; step("R7 ack without request");
        rd(0, 32'h0000_0200, "R7 ignored ack leaves latch");
        gie_set = 1; gie_clr = 1; step("R5 clear wins");
        step("R5 still disabled");
        // R10 latch cancel rules
        wr(0, 32'h0000_0200, 1); step("R10 cancel of unmasked bit");
        rd(0, 32'h0000_0200, "R10 unmasked bit kept");
        wr(1, 32'h0, 1); step("R10 mask all");
        wr(0, 32'h0000_0200, 0); step("R11 user cancel");
        rd(0, 32'h0000_0200, "R11 user cancel ignored");
        evt_raise = 16'h0400; wr(0, 32'h0000_0600, 1); step("R10 cancel with raise");
        rd(0, 32'h0000_0400, "R10 raise wins, 9 cleared");
        // R11 user mode
        wr(1, 32'hFFFF, 0); step("R11 user mask write");
        rd(1, 32'h0000_002F, "R11 mask unchanged");
        supervisor = 0; rd(0, 32'h0, "R11 user read zero");
        supervisor = 0; rd(1, 32'h0, "R11 user mask read zero");
        supervisor = 1;

        // random phase
        for (int c = 0; c < 4000; c++) begin
            evt_raise = 16'($urandom & $urandom & $urandom & $urandom);
            ack = ($urandom % 3) == 0;
            rfe = ($urandom % 4) == 0;
            gie_set = ($urandom % 16) == 0;
            gie_clr = ($urandom % 24) == 0;
            if (($urandom % 8) == 0) wr($urandom % 2, $urandom, ($urandom % 4) != 0);
            step("R6 R8 random cycle");
            if ((c % 100) == 0) begin
                rd(0, {16'h0, m_latch}, "R2 random latch read");
                rd(1, {16'h0, m_mask}, "R11 random mask read");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule